// File: doc/BRIEF.md
# Producer-Consumer Sharing Pattern Detector

This block sits beside a directory controller and keeps a few bits of access history for every directory cache slot. Each clock cycle the controller may present one coherence event for one slot: the slot was allocated, a node asked to read the line, a node asked to write it (or to own it exclusively), or the slot was flushed. From these events the block tracks who wrote the line last, how many different nodes have read it since that write, and how often the same writer has come back after readers looked at its data.

When the same node has returned to write three times, each time after at least one other node read the line, the block decides that the line shows a stable one-writer, many-reader pattern. It raises a one-cycle hit pulse together with the producing node's ID, so that a delegation stage further along can act on it. The detector is deliberately conservative: a write from any other node throws away the progress made so far. History lives only as long as the directory slot does. Allocation and flush both wipe it.

Every event is answered one cycle later on registered outputs that show the slot's updated history. This lets the controller store or forward the history without reading it a second time.

Top module: `share_pattern_detect`

## Requirements
- R1: An event with kind 0 (allocate) leaves the slot with writer 0, reader count 0, repeat count 0 and no pattern mark, and this cleared history is shown on the outputs one cycle later.
- R2: An event with kind 3 (flush) clears the slot's history in the same way as allocate. Events that follow start from that cleared history.
- R3: A write event (kind 2) always sets the slot's reader count to 0. The writer output shows the writing node one cycle later.
- R4: A read event (kind 1) from a node that has not yet read since the last write raises the reader count by one. The count saturates at 3.
- R5: A read from a node already counted since the last write, or a read from the recorded last writer, leaves the reader count unchanged.
- R6: A write from the recorded last writer, when the reader count is non-zero, raises the repeat count by one. The repeat count saturates at 3.
- R7: A write from the recorded last writer, when the reader count is zero, leaves the repeat count unchanged.
- R8: A write from any node other than the recorded last writer, including the first write after a clear, loads that node as writer and sets the repeat count to 0.
- R9: pc_hit is high for exactly one cycle, with pc_node equal to the writer, following the write that takes the repeat count from 2 to 3. Later writes that keep it at 3 give no pulse. out_pc_mark is high whenever the shown repeat count is 3.
- R10: Each slot's history changes only on events addressed to that slot.
- R11: While reset is high, and in any cycle that follows a cycle without an event, out_valid and pc_hit are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | An event is present this cycle |
| ev_kind | input | 2 | 0 allocate, 1 read, 2 write, 3 flush |
| ev_slot | input | SLOT_W | Directory cache slot addressed |
| ev_node | input | NODE_W | Requesting node ID |
| out_valid | output | 1 | Outputs below describe last cycle's event |
| out_writer | output | NODE_W | Updated last-writer field |
| out_readers | output | CNT_W | Updated distinct-reader count |
| out_repeat | output | CNT_W | Updated write-repeat count |
| out_pc_mark | output | 1 | Slot's repeat count is saturated |
| pc_hit | output | 1 | Pulse: this event made the line producer-consumer |
| pc_node | output | NODE_W | Producer node ID that goes with pc_hit |

## Verification
The hardest state to reach is the moment of saturation. Three separate write-after-read rounds by one node are needed, and none of them may be interrupted by a foreign writer, so random traffic seldom gets there on its own. The bench therefore runs a directed sequence on one slot that walks the repeat count up step by step. That sequence includes writes with no reads in between, reads by the writer itself, and duplicate readers, and each of these must not advance the count. It then runs a long pseudo-random stream in which one node is strongly favoured as writer and events are spread over four interleaved slots. Every event is compared against an arithmetic model kept in the bench.

// File: rtl/sd_pkg.sv
package sd_pkg;
  typedef enum logic [1:0] {
    EV_ALLOC = 2'd0,
    EV_READ  = 2'd1,
    EV_WRITE = 2'd2,
    EV_FLUSH = 2'd3
  } ev_kind_t;
endpackage

// File: rtl/sd_hist_update.sv
module sd_hist_update
  import sd_pkg::*;
#(
  parameter int NODE_W = 4,
  parameter int CNT_W  = 2,
  localparam int NODES = 1 << NODE_W
) (
  input  ev_kind_t          kind,
  input  logic [NODE_W-1:0] node,
  input  logic              c_hw,
  input  logic [NODE_W-1:0] c_wr,
  input  logic [CNT_W-1:0]  c_rc,
  input  logic [CNT_W-1:0]  c_rp,
  input  logic [NODES-1:0]  c_seen,
  output logic              n_hw,
  output logic [NODE_W-1:0] n_wr,
  output logic [CNT_W-1:0]  n_rc,
  output logic [CNT_W-1:0]  n_rp,
  output logic [NODES-1:0]  n_seen,
  output logic              hit
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CPRE = CMAX - 1'b1;

  logic same_writer;
  assign same_writer = c_hw && (node == c_wr);

  always_comb begin
    n_hw   = c_hw;
    n_wr   = c_wr;
    n_rc   = c_rc;
    n_rp   = c_rp;
    n_seen = c_seen;
    hit    = 1'b0;
    case (kind)
      EV_READ: begin
        if (!same_writer && !c_seen[node]) begin
          n_seen[node] = 1'b1;
          if (c_rc != CMAX) n_rc = c_rc + 1'b1;
        end
      end
      EV_WRITE: begin
        n_rc   = '0;
        n_seen = '0;
        if (same_writer) begin
          if (c_rc != '0 && c_rp != CMAX) begin
            n_rp = c_rp + 1'b1;
            hit  = (c_rp == CPRE);
          end
        end else begin
          n_hw = 1'b1;
          n_wr = node;
          n_rp = '0;
        end
      end
      default: begin
        n_hw   = 1'b0;
        n_wr   = '0;
        n_rc   = '0;
        n_rp   = '0;
        n_seen = '0;
      end
    endcase
  end
endmodule

// File: rtl/sd_entry_store.sv
module sd_entry_store #(
  parameter int SLOTS = 16,
  parameter int WIDTH = 25,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [SLOT_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [SLOT_W-1:0] raddr,
  output logic [WIDTH-1:0]  rdata
);
  logic [WIDTH-1:0] mem [SLOTS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/share_pattern_detect.sv
module share_pattern_detect
  import sd_pkg::*;
#(
  parameter int SLOTS  = 16,
  parameter int NODE_W = 4,
  parameter int CNT_W  = 2,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int NODES  = 1 << NODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  logic [1:0]        ev_kind,
  input  logic [SLOT_W-1:0] ev_slot,
  input  logic [NODE_W-1:0] ev_node,
  output logic              out_valid,
  output logic [NODE_W-1:0] out_writer,
  output logic [CNT_W-1:0]  out_readers,
  output logic [CNT_W-1:0]  out_repeat,
  output logic              out_pc_mark,
  output logic              pc_hit,
  output logic [NODE_W-1:0] pc_node
);
  localparam int ENT_W  = 1 + NODE_W + 2 * CNT_W + NODES;
  localparam int O_SEEN = 0;
  localparam int O_RP   = NODES;
  localparam int O_RC   = O_RP + CNT_W;
  localparam int O_WR   = O_RC + CNT_W;
  localparam int O_HW   = O_WR + NODE_W;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [ENT_W-1:0] cur, nxt;
  logic              n_hw, hit;
  logic [NODE_W-1:0] n_wr;
  logic [CNT_W-1:0]  n_rc, n_rp;
  logic [NODES-1:0]  n_seen;

  sd_entry_store #(.SLOTS(SLOTS), .WIDTH(ENT_W)) u_store (
    .clk   (clk),
    .we    (ev_valid && !rst),
    .waddr (ev_slot),
    .wdata (nxt),
    .raddr (ev_slot),
    .rdata (cur)
  );

  sd_hist_update #(.NODE_W(NODE_W), .CNT_W(CNT_W)) u_upd (
    .kind   (ev_kind_t'(ev_kind)),
    .node   (ev_node),
    .c_hw   (cur[O_HW]),
    .c_wr   (cur[O_WR +: NODE_W]),
    .c_rc   (cur[O_RC +: CNT_W]),
    .c_rp   (cur[O_RP +: CNT_W]),
    .c_seen (cur[O_SEEN +: NODES]),
    .n_hw   (n_hw),
    .n_wr   (n_wr),
    .n_rc   (n_rc),
    .n_rp   (n_rp),
    .n_seen (n_seen),
    .hit    (hit)
  );

  assign nxt = {n_hw, n_wr, n_rc, n_rp, n_seen};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_writer  <= '0;
      out_readers <= '0;
      out_repeat  <= '0;
      out_pc_mark <= 1'b0;
      pc_hit      <= 1'b0;
      pc_node     <= '0;
    end else begin
      out_valid   <= ev_valid;
      pc_hit      <= ev_valid && hit;
      if (ev_valid) begin
        out_writer  <= n_wr;
        out_readers <= n_rc;
        out_repeat  <= n_rp;
        out_pc_mark <= (n_rp == CMAX);
        pc_node     <= n_wr;
      end
    end
  end
endmodule

// File: rtl/share_pattern_detect_chk.sv
module share_pattern_detect_chk #(
  parameter int SLOT_W = 4,
  parameter int NODE_W = 4,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              ev_valid,
  input logic [1:0]        ev_kind,
  input logic [SLOT_W-1:0] ev_slot,
  input logic [NODE_W-1:0] ev_node,
  input logic              out_valid,
  input logic [NODE_W-1:0] out_writer,
  input logic [CNT_W-1:0]  out_readers,
  input logic [CNT_W-1:0]  out_repeat,
  input logic              out_pc_mark,
  input logic              pc_hit,
  input logic [NODE_W-1:0] pc_node
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  assert_alloc_clear_R1: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_kind == 2'd0) |=> (out_readers == '0 && out_repeat == '0 && !out_pc_mark && !pc_hit));

  assert_flush_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_kind == 2'd3) |=> (out_readers == '0 && out_repeat == '0 && !pc_hit));

  assert_write_load_R3: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_kind == 2'd2) |=> (out_writer == $past(ev_node) && out_readers == '0));

  assert_hit_shape_R9: assert property (@(posedge clk) disable iff (rst)
    pc_hit |-> (out_repeat == CMAX && out_pc_mark && pc_node == out_writer));

  assert_hit_cause_R9: assert property (@(posedge clk) disable iff (rst)
    pc_hit |-> $past(ev_valid && ev_kind == 2'd2));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !ev_valid |=> (!out_valid && !pc_hit));
endmodule

bind share_pattern_detect share_pattern_detect_chk #(
  .SLOT_W(SLOT_W), .NODE_W(NODE_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/share_pattern_detect_tb.sv
`timescale 1ns/1ps
module share_pattern_detect_tb;
  localparam int SL = 16;
  localparam int SW = 4;
  localparam int NW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ev_valid = 1'b0;
  logic [1:0]    ev_kind = '0;
  logic [SW-1:0] ev_slot = '0;
  logic [NW-1:0] ev_node = '0;
  logic          out_valid, out_pc_mark, pc_hit;
  logic [NW-1:0] out_writer, pc_node;
  logic [1:0]    out_readers, out_repeat;

  int checks = 0;
  int bad = 0;
  int hits = 0;
  bit done = 0;

  always #5 clk = ~clk;

  share_pattern_detect u_dut (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_slot(ev_slot), .ev_node(ev_node), .out_valid(out_valid),
    .out_writer(out_writer), .out_readers(out_readers), .out_repeat(out_repeat),
    .out_pc_mark(out_pc_mark), .pc_hit(pc_hit), .pc_node(pc_node)
  );

  // bench-side history, derived from the requirement text
  bit      m_hw   [SL];
  int      m_wr   [SL];
  int      m_rc   [SL];
  int      m_rp   [SL];
  bit [15:0] m_seen [SL];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // called at a falling edge; leaves at the next falling edge after checking
  task automatic do_ev(input int k, input int s, input int n);
    int  e_hit = 0;
    ev_valid = 1'b1;
    ev_kind  = k[1:0];
    ev_slot  = s[SW-1:0];
    ev_node  = n[NW-1:0];
    if (k == 0 || k == 3) begin          // R1, R2
      m_hw[s] = 0; m_wr[s] = 0; m_rc[s] = 0; m_rp[s] = 0; m_seen[s] = '0;
    end else if (k == 1) begin           // R4, R5
      if (!(m_hw[s] && m_wr[s] == n) && !m_seen[s][n]) begin
        m_seen[s][n] = 1'b1;
        if (m_rc[s] < 3) m_rc[s]++;
      end
    end else begin                       // R3, R6, R7, R8
      if (m_hw[s] && m_wr[s] == n) begin
        if (m_rc[s] != 0 && m_rp[s] < 3) begin
          m_rp[s]++;
          if (m_rp[s] == 3) e_hit = 1;
        end
      end else begin
        m_hw[s] = 1; m_wr[s] = n; m_rp[s] = 0;
      end
      m_rc[s] = 0; m_seen[s] = '0;
    end
    @(negedge clk);
    ev_valid = 1'b0;
    chk("R11 out_valid", 32'(out_valid), 32'd1);
    chk("R3/R8 writer", 32'(out_writer), 32'(m_wr[s]));
    chk("R4/R5 readers", 32'(out_readers), 32'(m_rc[s]));
    chk("R6/R7 repeat", 32'(out_repeat), 32'(m_rp[s]));
    chk("R9 mark", 32'(out_pc_mark), 32'(m_rp[s] == 3));
    chk("R9 hit", 32'(pc_hit), 32'(e_hit));
    if (e_hit == 1) begin
      hits++;
      chk("R9 pc_node", 32'(pc_node), 32'(n));
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 valid in reset", 32'(out_valid), 32'd0);
    chk("R11 hit in reset", 32'(pc_hit), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 idle valid", 32'(out_valid), 32'd0);
    for (int s = 0; s < SL; s++) do_ev(0, s, 0);   // R1 on every slot

    // directed walk to saturation on slot 5, slot 6 disturbed alongside (R10)
    do_ev(2, 5, 1);                // R8 first writer
    do_ev(1, 5, 2);                // R4
    do_ev(2, 6, 7);                // R10 other slot
    do_ev(2, 5, 1);                // R6 repeat 1
    do_ev(1, 5, 3); do_ev(1, 5, 3);// R5 duplicate reader
    do_ev(2, 5, 1);                // R6 repeat 2
    do_ev(2, 5, 1);                // R7 no reads between
    do_ev(1, 5, 1);                // R5 self read
    do_ev(2, 5, 1);                // R7 still 2
    do_ev(1, 5, 4);
    do_ev(2, 5, 1);                // R9 saturation pulse
    chk("R9 directed hit count", 32'(hits), 32'd1);
    do_ev(1, 5, 9);
    do_ev(2, 5, 1);                // R9 no second pulse
    chk("R9 single pulse", 32'(hits), 32'd1);
    for (int n = 2; n < 8; n++) do_ev(1, 5, n);   // R4 saturation of reader count
    do_ev(2, 5, 2);                // R8 foreign writer clears repeat
    do_ev(3, 5, 0);                // R2 flush
    do_ev(1, 5, 1);
    do_ev(2, 5, 2);                // R2 fresh start after flush
    do_ev(2, 6, 7);                // R10 slot 6 kept its writer

    // pseudo-random stream, one favoured writer, four interleaved slots
    for (int i = 0; i < 4000; i++) begin
      int k, s, n;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      s = 8 + int'(lf[1:0]);
      if (lf[15:8] < 8'd4) k = (lf[2] ? 3 : 0);
      else if (lf[7:5] < 3'd2) k = 2;
      else k = 1;
      if (k == 2) n = (lf[11:9] == 3'd0) ? 2 : 1;
      else n = int'(lf[12:10]);
      do_ev(k, s, n);
      if (lf[3] && lf[4] && lf[6]) begin
        @(negedge clk);
        chk("R11 gap", 32'(out_valid), 32'd0);
      end
    end
    chk("R9 random hits seen", 32'(hits > 1), 32'd1);
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule